// File: doc/BRIEF.md
# Linked-List Sharing Directory Controller

This block tracks which caches of a small multiprocessor hold a copy of each memory block. It does not use a sharer bit-vector. The home entry of a block stores one pointer, to the most recent sharer. Each cached copy carries a forward and a backward pointer, so the sharers of a block form a chain. The pointer fields of every cache are modelled inside the block.

A read from a node that does not yet hold the block links that node in front of the chain. A write walks the chain from its head. It sends one invalidation at a time and waits for the acknowledge before it follows the next pointer. At the end the writer is the only holder. An eviction unlinks one node in a single step, using its backward pointer. The controller takes one request at a time and raises `busy` until the request has completed. Each completion pulses `done` and reports the block's new head pointer. The all-ones node id is the null pointer: it marks the end of a chain and an empty block.

Top module: `llist_dir`

## Requirements
- R1: After reset every block is empty: `busy`, `done` and `inv_valid` are low, and a first write to a block completes with no invalidation and reports the writer as head.
- R2: A read (op 2'b00) by a non-holder is accepted on a clock edge while `busy` is low. `done` is high in the following cycle, with `resp_head` equal to the reader.
- R3: A read by a node already in the block's chain, and the reserved op 2'b11, complete one cycle later with the head unchanged and no node linked twice.
- R4: A write (op 2'b01) sends invalidations for the block in chain order from the head. That order is the reverse of the order in which the nodes joined. `inv_block` is the write's block.
- R5: An invalidation stays asserted, with a stable node and block, until `inv_ack` is sampled high. The next invalidation appears only after that acknowledge.
- R6: The writer is never sent an invalidation. When the write completes, `resp_head` is the writer and the writer is the block's only sharer.
- R7: `busy` is high from the cycle after acceptance through the `done` cycle. A request presented while `busy` is high is ignored.
- R8: An evict (op 2'b10) unlinks a head, middle or tail node in one cycle and reports the new head (all-ones when the chain becomes empty). An evict of a non-holder changes nothing.
- R9: Chains of different blocks are independent.
- R10: `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_node | input | NW | Requesting node id |
| req_block | input | BW | Block index |
| req_op | input | 2 | 00 read, 01 write, 10 evict, 11 reserved |
| busy | output | 1 | A request is in progress |
| inv_valid | output | 1 | Invalidation to send |
| inv_node | output | NW | Node to invalidate |
| inv_block | output | BW | Block being invalidated |
| inv_ack | input | 1 | Invalidation acknowledged |
| done | output | 1 | Request complete (one cycle) |
| resp_head | output | NW | Block head pointer while `done` is high |

## Verification
If a next or previous pointer is wrong, the error shows up at the next write to that block. The invalidation sequence then skips a node, repeats one, or comes out in the wrong order. If the home pointer is wrong, it shows up in `resp_head` at the very next completion on that block. The bench keeps a queue per block as its reference and checks every invalidation and every completion the cycle it appears. A corrupted link is therefore reported as soon as the next write to that block reaches it.

// File: rtl/llist_dir_pkg.sv
// Shared encodings for the linked-list sharing directory.
package llist_dir_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_EVICT = 2'b10,
        OP_NOP   = 2'b11
    } dir_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WALK,
        ST_FIN
    } dir_state_e;

    // Number of node write ports into the pointer store.
    localparam int WR_PORTS = 3;
endpackage

// File: rtl/llist_ptr_store.sv
// Pointer storage: the home head pointer per block, plus next/prev/valid for each
// (node, block) pair. Assumes one block is touched per cycle and that the write
// ports never target the same field of the same node in one cycle.
module llist_ptr_store
    import llist_dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    parameter int NW     = 3,
    parameter int BW     = 3,
    parameter int NIW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] blk,
    input  logic          home_we,
    input  logic [NW-1:0] home_wd,
    output logic [NW-1:0] home_rd,
    input  logic          wr_en       [WR_PORTS],
    input  logic [NW-1:0] wr_node     [WR_PORTS],
    input  logic          wr_next_en  [WR_PORTS],
    input  logic [NW-1:0] wr_next     [WR_PORTS],
    input  logic          wr_prev_en  [WR_PORTS],
    input  logic [NW-1:0] wr_prev     [WR_PORTS],
    input  logic          wr_valid_en [WR_PORTS],
    input  logic          wr_valid    [WR_PORTS],
    input  logic [NW-1:0] rd_node,
    output logic [NW-1:0] rd_next,
    output logic [NW-1:0] rd_prev,
    output logic          rd_valid
);
    localparam int          NSLOT = 1 << NIW;
    localparam int          BSLOT = 1 << BW;
    localparam logic [NW-1:0] NULLP = {NW{1'b1}};

    logic [NW-1:0] home_q  [BSLOT];
    logic [NW-1:0] next_q  [NSLOT][BSLOT];
    logic [NW-1:0] prev_q  [NSLOT][BSLOT];
    logic          valid_q [NSLOT][BSLOT];

    // Apply the home write and up to three node-field writes for the current block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < BSLOT; b++) begin
                home_q[b] <= NULLP;
                for (int n = 0; n < NSLOT; n++) begin
                    next_q[n][b]  <= NULLP;
                    prev_q[n][b]  <= NULLP;
                    valid_q[n][b] <= 1'b0;
                end
            end
        end else begin
            if (home_we) home_q[blk] <= home_wd;
            for (int p = 0; p < WR_PORTS; p++) begin
                if (wr_en[p] && wr_node[p] < NW'(NODES)) begin
                    if (wr_next_en[p])  next_q[wr_node[p][NIW-1:0]][blk]  <= wr_next[p];
                    if (wr_prev_en[p])  prev_q[wr_node[p][NIW-1:0]][blk]  <= wr_prev[p];
                    if (wr_valid_en[p]) valid_q[wr_node[p][NIW-1:0]][blk] <= wr_valid[p];
                end
            end
        end
    end

    // Combinational read of the head and one node's fields; null ids read as empty.
    always_comb begin
        home_rd  = home_q[blk];
        rd_next  = NULLP;
        rd_prev  = NULLP;
        rd_valid = 1'b0;
        if (rd_node < NW'(NODES)) begin
            rd_next  = next_q[rd_node[NIW-1:0]][blk];
            rd_prev  = prev_q[rd_node[NIW-1:0]][blk];
            rd_valid = valid_q[rd_node[NIW-1:0]][blk];
        end
    end

    for (genvar b = 0; b < BSLOT; b++) begin : g_chk
        AST_HEAD_IS_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
            (home_q[b] != NULLP) |-> valid_q[home_q[b][NIW-1:0]][b]) else $error("head not a holder"); // R8
        AST_HEAD_NO_PREV: assert property (@(posedge clk) disable iff (!rst_n)
            (home_q[b] != NULLP) |-> (prev_q[home_q[b][NIW-1:0]][b] == NULLP)) else $error("head has prev"); // R8
    end
endmodule

// File: rtl/llist_dir_ctrl.sv
// Request sequencer: handles read insertion and evict unlinking in one step, and
// walks the chain on a write, one acknowledged invalidation at a time. Assumes
// requested node ids are below NODES. Only accepts requests while idle.
module llist_dir_ctrl
    import llist_dir_pkg::*;
#(
    parameter int NW = 3,
    parameter int BW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [NW-1:0] req_node,
    input  logic [BW-1:0] req_block,
    input  logic [1:0]    req_op,
    output logic          busy,
    output logic          inv_valid,
    output logic [NW-1:0] inv_node,
    output logic [BW-1:0] inv_block,
    input  logic          inv_ack,
    output logic          done,
    output logic [NW-1:0] resp_head,
    output logic [BW-1:0] blk,
    output logic          home_we,
    output logic [NW-1:0] home_wd,
    input  logic [NW-1:0] home_rd,
    output logic          wr_en       [WR_PORTS],
    output logic [NW-1:0] wr_node     [WR_PORTS],
    output logic          wr_next_en  [WR_PORTS],
    output logic [NW-1:0] wr_next     [WR_PORTS],
    output logic          wr_prev_en  [WR_PORTS],
    output logic [NW-1:0] wr_prev     [WR_PORTS],
    output logic          wr_valid_en [WR_PORTS],
    output logic          wr_valid    [WR_PORTS],
    output logic [NW-1:0] rd_node,
    input  logic [NW-1:0] rd_next,
    input  logic [NW-1:0] rd_prev,
    input  logic          rd_valid
);
    localparam logic [NW-1:0] NULLP = {NW{1'b1}};

    dir_state_e    state_q;
    dir_op_e       op_q;
    logic [NW-1:0] node_q;
    logic [BW-1:0] blk_q;
    logic [NW-1:0] cur_q;

    logic accept, step, finish;

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign step   = (state_q == ST_WALK) && (cur_q != NULLP) && ((cur_q == node_q) || inv_ack);
    assign finish = (state_q == ST_WALK) && (cur_q == NULLP);

    assign blk       = (state_q == ST_IDLE) ? req_block : blk_q;
    assign rd_node   = (state_q == ST_IDLE) ? req_node : cur_q;
    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_FIN);
    assign resp_head = done ? home_rd : NULLP;
    assign inv_valid = (state_q == ST_WALK) && (cur_q != NULLP) && (cur_q != node_q);
    assign inv_node  = cur_q;
    assign inv_block = blk_q;

    // Decide the pointer updates for the current cycle.
    always_comb begin
        home_we = 1'b0;
        home_wd = NULLP;
        for (int p = 0; p < WR_PORTS; p++) begin
            wr_en[p] = 1'b0;       wr_node[p] = NULLP;
            wr_next_en[p] = 1'b0;  wr_next[p] = NULLP;
            wr_prev_en[p] = 1'b0;  wr_prev[p] = NULLP;
            wr_valid_en[p] = 1'b0; wr_valid[p] = 1'b0;
        end
        if (accept) begin
            case (dir_op_e'(req_op))
                OP_READ: if (!rd_valid) begin
                    home_we = 1'b1;  home_wd = req_node;
                    wr_en[0] = 1'b1; wr_node[0] = req_node;
                    wr_next_en[0] = 1'b1;  wr_next[0] = home_rd;
                    wr_prev_en[0] = 1'b1;  wr_prev[0] = NULLP;
                    wr_valid_en[0] = 1'b1; wr_valid[0] = 1'b1;
                    if (home_rd != NULLP) begin
                        wr_en[1] = 1'b1; wr_node[1] = home_rd;
                        wr_prev_en[1] = 1'b1; wr_prev[1] = req_node;
                    end
                end
                OP_WRITE: begin
                    home_we = 1'b1; home_wd = NULLP;
                end
                OP_EVICT: if (rd_valid) begin
                    wr_en[0] = 1'b1; wr_node[0] = req_node;
                    wr_next_en[0] = 1'b1; wr_prev_en[0] = 1'b1; wr_valid_en[0] = 1'b1;
                    if (rd_prev == NULLP) begin
                        home_we = 1'b1; home_wd = rd_next;
                    end else begin
                        wr_en[1] = 1'b1; wr_node[1] = rd_prev;
                        wr_next_en[1] = 1'b1; wr_next[1] = rd_next;
                    end
                    if (rd_next != NULLP) begin
                        wr_en[2] = 1'b1; wr_node[2] = rd_next;
                        wr_prev_en[2] = 1'b1; wr_prev[2] = rd_prev;
                    end
                end
                default: ;
            endcase
        end
        if (step) begin
            wr_en[0] = 1'b1; wr_node[0] = cur_q;
            wr_next_en[0] = 1'b1; wr_prev_en[0] = 1'b1; wr_valid_en[0] = 1'b1;
        end
        if (finish) begin
            home_we = 1'b1;  home_wd = node_q;
            wr_en[0] = 1'b1; wr_node[0] = node_q;
            wr_next_en[0] = 1'b1; wr_prev_en[0] = 1'b1;
            wr_valid_en[0] = 1'b1; wr_valid[0] = 1'b1;
        end
    end

    // Sequence a request: capture it, walk the chain on a write, then report completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_NOP;
            node_q  <= NULLP;
            blk_q   <= '0;
            cur_q   <= NULLP;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    op_q    <= dir_op_e'(req_op);
                    node_q  <= req_node;
                    blk_q   <= req_block;
                    cur_q   <= home_rd;
                    state_q <= (dir_op_e'(req_op) == OP_WRITE) ? ST_WALK : ST_FIN;
                end
                ST_WALK: begin
                    if (step)   cur_q   <= rd_next;
                    if (finish) state_q <= ST_FIN;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_INV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_ack) |=> (inv_valid && $stable(inv_node) && $stable(inv_block))) else $error("inv dropped"); // R5
    AST_NO_SELF_INV: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_node != node_q)) else $error("writer invalidated"); // R6
    AST_WRITER_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_WRITE) |-> (resp_head == node_q)) else $error("writer not head"); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done stretched"); // R10
    AST_INV_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (busy && !done)) else $error("inv outside walk"); // R7
    AST_READ_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_READ) |-> (resp_head != NULLP)) else $error("read left empty"); // R2
endmodule

// File: rtl/llist_dir.sv
// Top of the linked-list sharing directory: the request sequencer plus the pointer
// store. Assumes BLOCKS is a power of two and at least 2, and NODES is at least 2.
module llist_dir
    import llist_dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    localparam int NW    = $clog2(NODES + 1),
    localparam int BW    = $clog2(BLOCKS),
    localparam int NIW   = $clog2(NODES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [NW-1:0] req_node,
    input  logic [BW-1:0] req_block,
    input  logic [1:0]    req_op,
    output logic          busy,
    output logic          inv_valid,
    output logic [NW-1:0] inv_node,
    output logic [BW-1:0] inv_block,
    input  logic          inv_ack,
    output logic          done,
    output logic [NW-1:0] resp_head
);
    logic [BW-1:0] blk;
    logic          home_we;
    logic [NW-1:0] home_wd, home_rd;
    logic          wr_en       [WR_PORTS];
    logic [NW-1:0] wr_node     [WR_PORTS];
    logic          wr_next_en  [WR_PORTS];
    logic [NW-1:0] wr_next     [WR_PORTS];
    logic          wr_prev_en  [WR_PORTS];
    logic [NW-1:0] wr_prev     [WR_PORTS];
    logic          wr_valid_en [WR_PORTS];
    logic          wr_valid    [WR_PORTS];
    logic [NW-1:0] rd_node, rd_next, rd_prev;
    logic          rd_valid;

    llist_dir_ctrl #(.NW(NW), .BW(BW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_node(req_node), .req_block(req_block), .req_op(req_op),
        .busy(busy), .inv_valid(inv_valid), .inv_node(inv_node), .inv_block(inv_block),
        .inv_ack(inv_ack), .done(done), .resp_head(resp_head),
        .blk(blk), .home_we(home_we), .home_wd(home_wd), .home_rd(home_rd),
        .wr_en(wr_en), .wr_node(wr_node), .wr_next_en(wr_next_en), .wr_next(wr_next),
        .wr_prev_en(wr_prev_en), .wr_prev(wr_prev), .wr_valid_en(wr_valid_en), .wr_valid(wr_valid),
        .rd_node(rd_node), .rd_next(rd_next), .rd_prev(rd_prev), .rd_valid(rd_valid)
    );

    llist_ptr_store #(.NODES(NODES), .BLOCKS(BLOCKS), .NW(NW), .BW(BW), .NIW(NIW)) u_store (
        .clk(clk), .rst_n(rst_n), .blk(blk),
        .home_we(home_we), .home_wd(home_wd), .home_rd(home_rd),
        .wr_en(wr_en), .wr_node(wr_node), .wr_next_en(wr_next_en), .wr_next(wr_next),
        .wr_prev_en(wr_prev_en), .wr_prev(wr_prev), .wr_valid_en(wr_valid_en), .wr_valid(wr_valid),
        .rd_node(rd_node), .rd_next(rd_next), .rd_prev(rd_prev), .rd_valid(rd_valid)
    );
endmodule

// File: tb/llist_dir_test.sv
// Bench: per-block queues (head at index 0) model the chains; every completion and
// every invalidation is compared with the model in the cycle it appears.
module llist_dir_test;
    localparam int NODES  = 4;
    localparam int BLOCKS = 8;
    localparam int NW     = 3;
    localparam int BW     = 3;
    localparam logic [NW-1:0] NULLP = 3'b111;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [NW-1:0] req_node = '0;
    logic [BW-1:0] req_block = '0;
    logic [1:0]    req_op = 2'b00;
    logic          busy, inv_valid, inv_ack = 1'b0, done;
    logic [NW-1:0] inv_node, resp_head;
    logic [BW-1:0] inv_block;

    int total = 0;
    int bad = 0;
    int chain [BLOCKS][$];

    llist_dir #(.NODES(NODES), .BLOCKS(BLOCKS)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_node(req_node),
        .req_block(req_block), .req_op(req_op), .busy(busy), .inv_valid(inv_valid),
        .inv_node(inv_node), .inv_block(inv_block), .inv_ack(inv_ack), .done(done),
        .resp_head(resp_head)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_head(input int b);
        return (chain[b].size() == 0) ? int'(NULLP) : chain[b][0];
    endfunction

    function automatic bit member(input int b, input int n);
        foreach (chain[b][i]) if (chain[b][i] == n) return 1'b1;
        return 1'b0;
    endfunction

    // Present one request at a negedge; return at the negedge after acceptance.
    task automatic issue(input int n, input int b, input logic [1:0] op);
        @(negedge clk);
        check(busy == 1'b0, "R7 idle before request", busy, 0);
        req_valid = 1'b1; req_node = NW'(n); req_block = BW'(b); req_op = op;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R7 busy after accept", busy, 1);
    endtask

    // Single-step completion check for read, evict and reserved ops.
    task automatic finish_simple(input int b, input string req);
        check(done == 1'b1, req, done, 1);
        check(resp_head == NW'(model_head(b)), req, resp_head, model_head(b));
        check(inv_valid == 1'b0, req, inv_valid, 0);
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", done, 0);
        check(busy == 1'b0, "R7 busy clears", busy, 0);
    endtask

    task automatic do_read(input int n, input int b);
        if (!member(b, n)) chain[b].push_front(n);
        issue(n, b, 2'b00);
        finish_simple(b, "R2/R3 read completion");
    endtask

    task automatic do_evict(input int n, input int b);
        foreach (chain[b][i]) if (chain[b][i] == n) begin chain[b].delete(i); break; end
        issue(n, b, 2'b10);
        finish_simple(b, "R8 evict completion");
    endtask

    task automatic do_nop(input int b);
        issue(0, b, 2'b11);
        finish_simple(b, "R3 reserved op");
    endtask

    // Write: expect invalidations in chain order, skipping the writer; optionally
    // present an extra read while busy, which must be ignored.
    task automatic do_write(input int w, input int b, input int inject);
        int exp_q[$];
        int k = 0;
        int cyc = 0;
        foreach (chain[b][i]) if (chain[b][i] != w) exp_q.push_back(chain[b][i]);
        issue(w, b, 2'b01);
        while (!done && cyc < 100) begin
            cyc++;
            if (inv_valid) begin
                check(k < exp_q.size(), "R4 extra invalidation", k, exp_q.size());
                if (k < exp_q.size())
                    check(inv_node == NW'(exp_q[k]), "R4 invalidation order", inv_node, exp_q[k]);
                check(inv_node != NW'(w), "R6 writer not invalidated", inv_node, w);
                check(inv_block == BW'(b), "R4 invalidation block", inv_block, b);
                if (inject >= 0 && k == 0) begin
                    req_valid = 1'b1; req_node = NW'(inject); req_block = BW'(b); req_op = 2'b00;
                end
                for (int d = 0; d < k % 3; d++) begin
                    logic [NW-1:0] held;
                    held = inv_node;
                    @(negedge clk);
                    check(inv_valid && inv_node == held, "R5 invalidation held", inv_node, held);
                end
                inv_ack = 1'b1;
                @(negedge clk);
                inv_ack = 1'b0;
                req_valid = 1'b0;
                k++;
            end else begin
                @(negedge clk);
            end
        end
        check(k == exp_q.size(), "R4 invalidation count", k, exp_q.size());
        check(done == 1'b1, "R6 write completes", done, 1);
        check(resp_head == NW'(w), "R6 writer is head", resp_head, w);
        chain[b].delete();
        chain[b].push_back(w);
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", done, 0);
    endtask

    initial begin
        #(200000 * 10);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1 reset busy", busy, 0);
        check(done == 1'b0, "R1 reset done", done, 0);
        check(inv_valid == 1'b0, "R1 reset inv_valid", inv_valid, 0);

        do_write(2, 0, -1);            // R1: empty block, no invalidations
        do_read(0, 0);                 // R2
        do_read(1, 0);
        do_read(3, 0);                 // chain 3,1,0,2
        do_read(1, 0);                 // R3 duplicate
        do_nop(0);                     // R3 reserved op
        do_read(1, 5);                 // R9 other block
        do_write(0, 0, -1);            // R4 expect 3,1,2
        do_write(2, 5, -1);            // R9 expect 1 only
        do_write(3, 0, -1);            // R6 expect 0 only

        do_read(0, 1); do_read(1, 1); do_read(2, 1); do_read(3, 1);  // 3,2,1,0
        do_evict(1, 1);                // R8 middle
        do_evict(3, 1);                // R8 head
        do_evict(0, 1);                // R8 tail
        do_evict(0, 1);                // R8 non-holder ignored
        do_write(3, 1, -1);            // R8 expect 2 only
        do_evict(3, 1);                // R8 empty -> all-ones head

        do_read(1, 2);
        do_write(2, 2, 3);             // R7 read of 3 during walk ignored
        do_write(0, 2, -1);            // R7 expect 2 only

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule